// File: doc/BRIEF.md
# Dual-Pipe Instruction Pairing Dispatcher

This block sits between instruction decode and two integer execution pipes, called X and Y. Each clock it looks at up to two decoded instructions in program order. Slot 0 is the older one and slot 1 the younger. Each instruction carries a two-bit class: simple (0), branch (1), floating point (2) or exclusive (3). It also carries a multi-cycle flag and an opaque payload. The block decides which of the two instructions issue this cycle and to which pipe. Any instruction it does not take is left with the upstream stage, which presents it again as the older candidate on the next clock.

Only simple instructions may enter Y. Non-simple instructions always go to X. A branch or floating-point instruction may still share its cycle with a younger simple instruction in Y. An exclusive instruction always travels alone. Two simple instructions pair even if one depends on the other, because the block never inspects operands. When a simple instruction issues on its own, it goes to the pipe with fewer outstanding multi-cycle operations. Each pipe keeps a saturating counter for this: the counter rises when a flagged instruction is accepted by that pipe and falls on that pipe's completion pulse.

Back-pressure rules:
- Both input slots and both pipes use valid/ready.
- The pipe-side valids are formed in the same cycle from the input valids and the pipe readies. A downstream ready must therefore never depend on its own valid.
- Upstream must treat slot 1 as accepted only together with slot 0. It must present a valid slot 1 only behind a valid slot 0.

Top module: `dual_pipe_dispatch`

## Requirements
- R1: When both slots are accepted in one cycle, pipe X carries slot 0 (class, multi flag and payload unchanged) and pipe Y carries slot 1.
- R2: Pipe Y only ever receives class 0 (simple) instructions.
- R3: A class 3 (exclusive) instruction in slot 0 issues to X alone: Y stays idle and slot 1 is not accepted.
- R4: A class 1 or 2 instruction in slot 0 issues to X, and a simple slot 1 issues to Y in the same cycle when Y is ready.
- R5: Two simple instructions pair (slot 0 to X, slot 1 to Y) whenever both pipes are ready, regardless of their payloads.
- R6: A simple slot 0 that issues without a partner goes to Y when Y is ready and Y's outstanding count is strictly below X's. Otherwise it goes to X, so a tie picks X.
- R7: Each pipe's outstanding count rises by one on an accepted multi-flagged issue and falls by one on its done pulse. Both in one cycle leave it unchanged. It saturates at LOAD_MAX and does not go below zero.
- R8: While x_ready is low, nothing issues and neither input slot is accepted.
- R9: Slot 1 is never accepted without slot 0. A valid slot 1 behind an invalid slot 0 is ignored.
- R10: A slot 1 that is not simple, or that follows an exclusive instruction, or that meets a low y_ready, is held (in1_ready low) while slot 0 still issues.
- R11: After reset both outstanding counts are zero, so the first lone simple instruction goes to X.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in0_valid | input | 1 | Older candidate present |
| in0_cls | input | 2 | Older class: 0 simple, 1 branch, 2 float, 3 exclusive |
| in0_multi | input | 1 | Older instruction is multi-cycle |
| in0_data | input | DATA_W | Older payload |
| in0_ready | output | 1 | Older candidate accepted this cycle |
| in1_valid | input | 1 | Younger candidate present |
| in1_cls | input | 2 | Younger class |
| in1_multi | input | 1 | Younger instruction is multi-cycle |
| in1_data | input | DATA_W | Younger payload |
| in1_ready | output | 1 | Younger candidate accepted this cycle |
| x_valid | output | 1 | Issue to pipe X |
| x_ready | input | 1 | Pipe X can accept |
| x_cls | output | 2 | Class issued to X |
| x_multi | output | 1 | Multi flag issued to X |
| x_data | output | DATA_W | Payload issued to X |
| x_done | input | 1 | A multi-cycle operation in X finished |
| y_valid | output | 1 | Issue to pipe Y |
| y_ready | input | 1 | Pipe Y can accept |
| y_cls | output | 2 | Class issued to Y |
| y_multi | output | 1 | Multi flag issued to Y |
| y_data | output | DATA_W | Payload issued to Y |
| y_done | input | 1 | A multi-cycle operation in Y finished |

## Verification
The hardest situation to reach is a lone simple instruction landing in Y. The outstanding counters are not visible at the ports, so this needs Y's count strictly below X's. The saturation and zero-floor corners are similar, because they show up only through where a later lone instruction lands. The stimulus first runs a full sweep of classes, valids and readies several times, with multi flags and done pulses varying from pass to pass, so that the two counts drift apart in both directions. It then pumps multi-cycle branches into X past the ceiling, loads Y to the same ceiling through pairs, and retires pulses past zero. After each stage it probes with a lone simple instruction whose placement only a saturating, floored count predicts.

// File: rtl/dpd_pkg.sv
package dpd_pkg;

  typedef enum logic [1:0] {
    CLS_SIMPLE = 2'd0,
    CLS_BRANCH = 2'd1,
    CLS_FLOAT  = 2'd2,
    CLS_EXCL   = 2'd3
  } iclass_e;

  typedef struct packed {
    logic x_en;        // slot 0 goes to X
    logic y_en;        // something goes to Y
    logic y_from_old;  // Y takes slot 0 (lone simple)
    logic take0;
    logic take1;
  } steer_t;

  localparam int NPIPE = 2;
  localparam int PIPE_X = 0;
  localparam int PIPE_Y = 1;

endpackage

// File: rtl/dpd_load_tracker.sv
module dpd_load_tracker #(
  parameter int MAX = 7,
  parameter int CW  = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          dec,
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] CAP = CW'(MAX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (inc && !dec) begin
      if (cnt != CAP) cnt <= cnt + 1'b1;
    end else if (dec && !inc) begin
      if (cnt != '0) cnt <= cnt - 1'b1;
    end
  end

  assert_load_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CAP);
  assert_load_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !dec && cnt < CAP) |=> cnt == $past(cnt) + 1'b1);
  assert_load_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !inc && cnt != '0) |=> cnt == $past(cnt) - 1'b1);
  assert_load_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (inc == dec) |=> $stable(cnt));

endmodule

// File: rtl/dpd_pair_steer.sv
module dpd_pair_steer
  import dpd_pkg::*;
(
  input  logic    v0,
  input  iclass_e c0,
  input  logic    v1,
  input  iclass_e c1,
  input  logic    x_rdy,
  input  logic    y_rdy,
  input  logic    y_lighter,
  output steer_t  st
);
  logic can_pair;

  // younger joins only as a simple op, never beside an exclusive one
  always_comb begin
    can_pair = v1 && (c1 == CLS_SIMPLE) && y_rdy && (c0 != CLS_EXCL);
  end

  always_comb begin
    st = '0;
    if (v0 && x_rdy) begin
      st.take0 = 1'b1;
      st.x_en  = 1'b1;
      if (can_pair) begin
        st.y_en  = 1'b1;
        st.take1 = 1'b1;
      end else if (c0 == CLS_SIMPLE && y_rdy && y_lighter) begin
        st.x_en       = 1'b0;
        st.y_en       = 1'b1;
        st.y_from_old = 1'b1;
      end
    end
  end

endmodule

// File: rtl/dual_pipe_dispatch.sv
module dual_pipe_dispatch
  import dpd_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int LOAD_MAX = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in0_valid,
  input  logic [1:0]        in0_cls,
  input  logic              in0_multi,
  input  logic [DATA_W-1:0] in0_data,
  output logic              in0_ready,
  input  logic              in1_valid,
  input  logic [1:0]        in1_cls,
  input  logic              in1_multi,
  input  logic [DATA_W-1:0] in1_data,
  output logic              in1_ready,
  output logic              x_valid,
  input  logic              x_ready,
  output logic [1:0]        x_cls,
  output logic              x_multi,
  output logic [DATA_W-1:0] x_data,
  input  logic              x_done,
  output logic              y_valid,
  input  logic              y_ready,
  output logic [1:0]        y_cls,
  output logic              y_multi,
  output logic [DATA_W-1:0] y_data,
  input  logic              y_done
);
  localparam int CW = $clog2(LOAD_MAX + 1);

  steer_t           st;
  logic [CW-1:0]    load_q [NPIPE];
  logic [NPIPE-1:0] load_inc;
  logic [NPIPE-1:0] load_dec;
  logic             y_lighter;

  always_comb y_lighter = load_q[PIPE_Y] < load_q[PIPE_X];

  dpd_pair_steer u_steer (
    .v0        (in0_valid),
    .c0        (iclass_e'(in0_cls)),
    .v1        (in1_valid),
    .c1        (iclass_e'(in1_cls)),
    .x_rdy     (x_ready),
    .y_rdy     (y_ready),
    .y_lighter (y_lighter),
    .st        (st)
  );

  always_comb begin
    in0_ready = st.take0;
    in1_ready = st.take1;
    x_valid   = st.x_en;
    x_cls     = in0_cls;
    x_multi   = in0_multi;
    x_data    = in0_data;
    y_valid   = st.y_en;
    y_cls     = st.y_from_old ? in0_cls   : in1_cls;
    y_multi   = st.y_from_old ? in0_multi : in1_multi;
    y_data    = st.y_from_old ? in0_data  : in1_data;
  end

  always_comb begin
    load_inc[PIPE_X] = x_valid && x_ready && x_multi;
    load_inc[PIPE_Y] = y_valid && y_ready && y_multi;
    load_dec[PIPE_X] = x_done;
    load_dec[PIPE_Y] = y_done;
  end

  for (genvar p = 0; p < NPIPE; p++) begin : g_load
    dpd_load_tracker #(.MAX(LOAD_MAX), .CW(CW)) u_load (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (load_inc[p]),
      .dec   (load_dec[p]),
      .cnt   (load_q[p])
    );
  end

  assert_y_simple_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    y_valid |-> y_cls == CLS_SIMPLE);
  assert_excl_alone_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (x_valid && x_cls == CLS_EXCL) |-> (!y_valid && !in1_ready));
  assert_x_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !x_ready |-> (!x_valid && !y_valid && !in0_ready && !in1_ready));
  assert_young_after_old_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in1_ready |-> in0_ready);
  assert_pair_routing_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in1_ready |-> (x_valid && y_valid && x_data == in0_data && y_data == in1_data));
  assert_issue_accepted_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (x_valid || y_valid) |-> in0_ready);

endmodule

// File: tb/dual_pipe_dispatch_tb.sv
module dual_pipe_dispatch_tb;
  localparam int DW = 16;
  localparam int LM = 7;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n;
  logic          in0_valid, in0_multi, in0_ready;
  logic [1:0]    in0_cls;
  logic [DW-1:0] in0_data;
  logic          in1_valid, in1_multi, in1_ready;
  logic [1:0]    in1_cls;
  logic [DW-1:0] in1_data;
  logic          x_valid, x_ready, x_multi, x_done;
  logic [1:0]    x_cls;
  logic [DW-1:0] x_data;
  logic          y_valid, y_ready, y_multi, y_done;
  logic [1:0]    y_cls;
  logic [DW-1:0] y_data;

  dual_pipe_dispatch #(.DATA_W(DW), .LOAD_MAX(LM)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .in0_valid(in0_valid), .in0_cls(in0_cls), .in0_multi(in0_multi),
    .in0_data(in0_data), .in0_ready(in0_ready),
    .in1_valid(in1_valid), .in1_cls(in1_cls), .in1_multi(in1_multi),
    .in1_data(in1_data), .in1_ready(in1_ready),
    .x_valid(x_valid), .x_ready(x_ready), .x_cls(x_cls), .x_multi(x_multi),
    .x_data(x_data), .x_done(x_done),
    .y_valid(y_valid), .y_ready(y_ready), .y_cls(y_cls), .y_multi(y_multi),
    .y_data(y_data), .y_done(y_done)
  );

  int n_run  = 0;
  int n_fail = 0;
  int mx = 0;  // bench estimate of outstanding ops in X
  int my = 0;  // and in Y

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int nxt(input int c, input bit i, input bit d);
    if (i && !d) return (c < LM) ? c + 1 : c;
    if (d && !i) return (c > 0) ? c - 1 : c;
    return c;
  endfunction

  task automatic drive_idle();
    in0_valid = 0; in0_cls = 0; in0_multi = 0; in0_data = '0;
    in1_valid = 0; in1_cls = 0; in1_multi = 0; in1_data = '0;
    x_ready = 0; y_ready = 0; x_done = 0; y_done = 0;
  endtask

  task automatic do_reset();
    drive_idle();
    rst_n = 0;
    mx = 0; my = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
  endtask

  task automatic step(input logic [1:0] c0, input logic [1:0] c1,
                      input bit v0, input bit v1, input bit xr, input bit yr,
                      input bit m0, input bit m1, input bit dx, input bit dy,
                      input logic [DW-1:0] d0, input logic [DW-1:0] d1,
                      input string force_tag);
    bit exv, eyv, eyold, et0, et1, pair;
    string tag;
    logic [DW+2:0] exp_y, act_y;
    in0_valid = v0; in0_cls = c0; in0_multi = m0; in0_data = d0;
    in1_valid = v1; in1_cls = c1; in1_multi = m1; in1_data = d1;
    x_ready = xr; y_ready = yr; x_done = dx; y_done = dy;
    #2;
    exv = 0; eyv = 0; eyold = 0; et0 = 0; et1 = 0; pair = 0;
    if (v0 && xr) begin
      exv = 1; et0 = 1;
      pair = v1 && (c1 == 2'd0) && yr && (c0 != 2'd3);
      if (pair) begin
        eyv = 1; et1 = 1;
      end else if (c0 == 2'd0 && yr && my < mx) begin
        exv = 0; eyv = 1; eyold = 1;
      end
    end
    if (force_tag != "")          tag = force_tag;
    else if (!xr)                 tag = "R8";
    else if (!v0)                 tag = "R9";
    else if (c0 == 2'd3)          tag = "R3";
    else if (et1 && c0 == 2'd0)   tag = "R5";
    else if (et1)                 tag = "R4";
    else if (v1)                  tag = "R10";
    else                          tag = "R6";
    chk({in0_ready, in1_ready, x_valid, y_valid} == {et0, et1, exv, eyv}, tag,
        "ready0,ready1,xv,yv", 32'({in0_ready, in1_ready, x_valid, y_valid}),
        32'({et0, et1, exv, eyv}));
    if (exv)
      chk({x_cls, x_multi, x_data} == {c0, m0, d0}, "R1", "x payload",
          32'({x_cls, x_multi, x_data}), 32'({c0, m0, d0}));
    if (eyv) begin
      exp_y = eyold ? {c0, m0, d0} : {c1, m1, d1};
      act_y = {y_cls, y_multi, y_data};
      chk(act_y == exp_y, eyold ? "R6" : "R1", "y payload", 32'(act_y), 32'(exp_y));
      chk(y_cls == 2'd0, "R2", "y class", 32'(y_cls), 32'd0);
    end
    @(posedge clk);
    mx = nxt(mx, exv && m0, dx);
    my = nxt(my, eyv && (eyold ? m0 : m1), dy);
    @(negedge clk);
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    // R11: idle after reset accepts nothing
    #2;
    chk({in0_ready, in1_ready, x_valid, y_valid} == 4'b0, "R11", "idle",
        32'({in0_ready, in1_ready, x_valid, y_valid}), 32'd0);
    @(negedge clk);
    // R11: counts start equal, lone simple goes to X
    step(2'd0, 2'd0, 1, 0, 1, 1, 0, 0, 0, 0, 16'h1111, 16'h2222, "R11");

    // full sweep of classes, valids and readies; loads drift between passes
    for (int r = 0; r < 6; r++) begin
      for (int k = 0; k < 256; k++) begin
        step(2'(k), 2'(k >> 2), bit'(k >> 4), bit'(k >> 5), bit'(k >> 6), bit'(k >> 7),
             bit'(((k * 7) + r) >> 2), bit'((k >> 1) + r),
             bit'(((k + 3 * r) % 5) == 0), bit'(((k + r) % 3) == 0),
             16'(k * 3 + r * 401), 16'(~(k * 5 + r)), "");
      end
    end

    // R7: saturation and floor, probed through lone-simple placement
    do_reset();
    for (int i = 0; i < 10; i++)   // branches with multi: X climbs to its cap
      step(2'd1, 2'd0, 1, 0, 1, 1, 1, 0, 0, 0, 16'(i), 16'h0, "R7");
    for (int i = 0; i < 7; i++)    // pairs load Y to the same cap
      step(2'd0, 2'd0, 1, 1, 1, 1, 0, 1, 0, 0, 16'(i + 32), 16'(i + 64), "R7");
    step(2'd0, 2'd0, 1, 0, 1, 1, 0, 0, 0, 0, 16'hA5A5, 16'h0, "R7");  // tie -> X
    for (int i = 0; i < 2; i++)    // Y drops to 5
      step(2'd0, 2'd0, 0, 0, 1, 1, 0, 0, 0, 1, 16'h0, 16'h0, "R7");
    step(2'd0, 2'd0, 1, 0, 1, 1, 0, 0, 0, 0, 16'h5A5A, 16'h0, "R7");  // Y lighter
    for (int i = 0; i < 10; i++)   // both retire past zero
      step(2'd0, 2'd0, 0, 0, 1, 1, 0, 0, 1, 1, 16'h0, 16'h0, "R7");
    step(2'd0, 2'd0, 1, 0, 1, 1, 0, 0, 0, 0, 16'h3C3C, 16'h0, "R7");  // 0 vs 0 -> X
    // R10: Y busy holds the younger simple while the older issues
    step(2'd2, 2'd0, 1, 1, 1, 0, 0, 0, 0, 0, 16'h7777, 16'h8888, "R10");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule